// File: doc/BRIEF.md
# Select-Steered Add/Multiply Datapath with Operand Isolation

This block computes one of two arithmetic results from two operand pairs. The first pair (A, B) feeds an unsigned adder and the second pair (C, D) feeds an unsigned multiplier. A single select input does two jobs. It picks which pair is registered, and later it picks which unit's output is written to the result register. Each pair has its own operand registers. Only the selected pair's registers are written, and only in a cycle where the load strobe is high. The other pair's registers keep their values, so the unused unit's inputs do not toggle.

Each strobe is one transaction. The select value in force at the strobe travels with that transaction. One edge after capture, the result register takes the chosen unit's output and a valid flag pulses for one cycle. The load strobe acts as the input valid. The result side has no ready and applies no back-pressure: a consumer must take each result in the cycle its valid flag is high. The registered operand pairs are brought out as ports so that the held state can be observed.

Top module: `twin_op_path`

## Requirements
- R1: With `ld`=1 and `sel`=0 at a rising edge, `pair0_q` becomes {A, B} at that edge. A sits in the upper W bits.
- R2: With `ld`=1 and `sel`=1 at a rising edge, `pair1_q` becomes {C, D} at that edge. C sits in the upper W bits.
- R3: A capture with `sel`=0 sets `res` to (A + B) mod 2^RW at the following rising edge.
- R4: A capture with `sel`=1 sets `res` to the low RW bits of C × D at the following rising edge.
- R5: During a strobe, the operand pair that is not selected keeps its previous value.
- R6: While `ld`=0, neither operand pair changes. One edge later `res` also holds.
- R7: `res_vld` is 1 in exactly the cycle after each result update and 0 otherwise. No back-pressure is applied.
- R8: A synchronous active-high `rst` clears both operand pairs, `res` and `res_vld`, and drops any capture in flight.
- R9: Back-to-back strobes with a changing select each produce the result of their own operation, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Load strobe (input valid); enables operand capture |
| sel | input | 1 | 0: add pair (A, B); 1: multiply pair (C, D) |
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| c_in | input | W | Operand C |
| d_in | input | W | Operand D |
| pair0_q | output | 2W | Registered {A, B} |
| pair1_q | output | 2W | Registered {C, D} |
| res | output | RW | Result register |
| res_vld | output | 1 | One-cycle flag marking a result update |

## Verification
The bench builds the block with its defaults of W = 8 and RW = 8. At that width, random operands often overflow the adder and often drive the product well past the truncation point. This makes the wrap cases (255 + 255 gives 254, 255 × 255 gives 1) easy to hit alongside the directed ones. The 8-bit operands also keep the two pairs distinct enough for a random stream to show any stray write into the held pair. Strobes, idle cycles and select changes are mixed freely, together with a reset asserted while a capture is in flight.

// File: rtl/twin_op_pkg.sv
package twin_op_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } op_kind_e;
endpackage

// File: rtl/operand_bank.sv
module operand_bank #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   y_in,
  output logic [2*W-1:0] pair_q
);
  always_ff @(posedge clk) begin
    if (rst)     pair_q <= '0;
    else if (en) pair_q <= {x_in, y_in};
  end
endmodule

// File: rtl/op_unit.sv
module op_unit
  import twin_op_pkg::*;
#(
  parameter int       W    = 8,
  parameter int       RW   = 8,
  parameter op_kind_e KIND = OP_ADD
) (
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  output logic [RW-1:0] z
);
  localparam int PW = 2 * W;
  logic [PW-1:0] full;

  generate
    if (KIND == OP_MUL) begin : g_mul
      always_comb full = PW'(x) * PW'(y);
    end else begin : g_add
      always_comb full = PW'(x) + PW'(y);
    end
  endgenerate

  assign z = full[RW-1:0];
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_i,
  input  logic          sel_i,
  input  logic [RW-1:0] sum_i,
  input  logic [RW-1:0] prod_i,
  output logic [RW-1:0] res_o,
  output logic          vld_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) res_o <= sel_i ? prod_i : sum_i;
    end
  end

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(res_o));

  // R7
  vld_follows_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> vld_o);
endmodule

// File: rtl/twin_op_path.sv
module twin_op_path
  import twin_op_pkg::*;
#(
  parameter int W  = 8,
  parameter int RW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic           sel,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [W-1:0]   c_in,
  input  logic [W-1:0]   d_in,
  output logic [2*W-1:0] pair0_q,
  output logic [2*W-1:0] pair1_q,
  output logic [RW-1:0]  res,
  output logic           res_vld
);
  localparam int NPAIR = 2;

  logic [2*W-1:0] pair_q [NPAIR];
  logic [RW-1:0]  unit_z [NPAIR];
  logic           cap_q;
  logic           sel_q;

  generate
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      logic [W-1:0] xi, yi;
      if (i == 0) begin : g_ab
        assign xi = a_in;
        assign yi = b_in;
      end else begin : g_cd
        assign xi = c_in;
        assign yi = d_in;
      end

      operand_bank #(.W(W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .en    (ld && (sel == 1'(i))),
        .x_in  (xi),
        .y_in  (yi),
        .pair_q(pair_q[i])
      );

      op_unit #(.W(W), .RW(RW), .KIND(i == 0 ? OP_ADD : OP_MUL)) u_unit (
        .x(pair_q[i][2*W-1:W]),
        .y(pair_q[i][W-1:0]),
        .z(unit_z[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      cap_q <= ld;
      if (ld) sel_q <= sel;
    end
  end

  result_stage #(.RW(RW)) u_res (
    .clk   (clk),
    .rst   (rst),
    .cap_i (cap_q),
    .sel_i (sel_q),
    .sum_i (unit_z[0]),
    .prod_i(unit_z[1]),
    .res_o (res),
    .vld_o (res_vld)
  );

  assign pair0_q = pair_q[0];
  assign pair1_q = pair_q[1];

  // R5
  mul_pair_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && !sel) |=> $stable(pair1_q));

  // R5
  add_pair_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && sel) |=> $stable(pair0_q));

  // R6
  idle_pairs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(pair0_q) && $stable(pair1_q)));

  // R1
  add_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && !sel) |=> (pair0_q == {$past(a_in), $past(b_in)}));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res == '0 && !res_vld && pair0_q == '0 && pair1_q == '0));
endmodule

// File: tb/test_twin_op_path.sv
module test_twin_op_path;
  localparam int W  = 8;
  localparam int RW = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ld = 1'b0, sel = 1'b0;
  logic [W-1:0]   a_in = '0, b_in = '0, c_in = '0, d_in = '0;
  logic [2*W-1:0] pair0_q, pair1_q;
  logic [RW-1:0]  res;
  logic           res_vld;

  always #2 clk = ~clk;

  twin_op_path #(.W(W), .RW(RW)) i_twin_op_path (
    .clk(clk), .rst(rst), .ld(ld), .sel(sel),
    .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
    .pair0_q(pair0_q), .pair1_q(pair1_q), .res(res), .res_vld(res_vld)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string ctx = "";

  // bench model state
  logic [2*W-1:0] m_p0 = '0, m_p1 = '0;
  logic [RW-1:0]  m_res = '0;
  logic           m_vld = 1'b0, m_cap = 1'b0, m_sel = 1'b0, m_rsel = 1'b0;
  logic           l_ld = 1'b0, l_sel = 1'b0, l_rst = 1'b1;

  function automatic logic [RW-1:0] f_add(logic [2*W-1:0] p);
    logic [2*W:0] s = {1'b0, p[2*W-1:W]} + {1'b0, p[W-1:0]};
    return s[RW-1:0];
  endfunction

  function automatic logic [RW-1:0] f_mul(logic [2*W-1:0] p);
    logic [2*W-1:0] m = {{W{1'b0}}, p[2*W-1:W]} * {{W{1'b0}}, p[W-1:0]};
    return m[RW-1:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic check_all();
    string t0, t1, tr;
    if (l_rst) begin
      t0 = "R8"; t1 = "R8"; tr = "R8";
    end else begin
      t0 = !l_ld ? "R6" : (l_sel ? "R5" : "R1");
      t1 = !l_ld ? "R6" : (l_sel ? "R2" : "R5");
      tr = m_vld ? (m_rsel ? "R4" : "R3") : "R6";
    end
    chk(t0, 32'(pair0_q), 32'(m_p0));
    chk(t1, 32'(pair1_q), 32'(m_p1));
    chk(tr, 32'(res), 32'(m_res));
    chk(l_rst ? "R8" : "R7", 32'(res_vld), 32'(m_vld));
  endtask

  task automatic step(logic r, logic l, logic s,
                      logic [W-1:0] a, logic [W-1:0] b,
                      logic [W-1:0] c, logic [W-1:0] d);
    @(negedge clk);
    check_all();
    rst = r; ld = l; sel = s; a_in = a; b_in = b; c_in = c; d_in = d;
    if (r) begin
      m_p0 = '0; m_p1 = '0; m_res = '0; m_vld = 1'b0; m_cap = 1'b0; m_sel = 1'b0;
    end else begin
      m_vld = m_cap;
      if (m_cap) begin
        m_res  = m_sel ? f_mul(m_p1) : f_add(m_p0);
        m_rsel = m_sel;
      end
      if (l && !s) m_p0 = {a, b};
      if (l && s)  m_p1 = {c, d};
      m_cap = l;
      if (l) m_sel = s;
    end
    l_rst = r; l_ld = l; l_sel = s;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00c0ffee);
    ctx = "reset";
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    // directed: wrap corners for R3/R4
    ctx = "corners";
    step(0, 1, 0, 8'hff, 8'hff, 8'h11, 8'h22);
    step(0, 0, 1, 8'h01, 8'h02, 8'h03, 8'h04);
    step(0, 1, 1, 8'h5a, 8'ha5, 8'hff, 8'hff);
    step(0, 0, 0, 8'h77, 8'h88, 8'h99, 8'haa);
    step(0, 1, 0, 8'h00, 8'h00, 8'h10, 8'h10);
    step(0, 0, 1, 8'h33, 8'h44, 8'h55, 8'h66);
    step(0, 0, 0, 8'h12, 8'h34, 8'h56, 8'h78);
    // R9: back-to-back alternating selects
    ctx = "R9 back-to-back";
    for (int i = 0; i < 8; i++)
      step(0, 1, 1'(i), 8'(i * 37), 8'(i * 11 + 3), 8'(i * 29 + 7), 8'(i * 13 + 5));
    step(0, 0, 0, 0, 0, 0, 0);
    // R8: reset with a capture in flight
    ctx = "R8 mid-flight reset";
    step(0, 1, 1, 8'h21, 8'h43, 8'h65, 8'h87);
    step(1, 1, 0, 8'h99, 8'h98, 8'h97, 8'h96);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // random mix
    ctx = "random";
    for (int i = 0; i < 2000; i++) begin
      logic l;
      l = ($urandom % 10) < 7;
      step(0, l, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end
    ctx = "drain";
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule